// File: doc/BRIEF.md
# Low Pin Count Flash Target Cycle Front-End

This block is the bus-facing controller of a flash device attached to a Low Pin Count bus. It samples a 4-bit multiplexed address/data bus and an active-low frame strobe on every rising clock edge. It recognises the start of a target cycle and takes in the cycle-type nibble and eight address nibbles. It then decides whether this device is the one addressed, by comparing two address bits against two strap inputs. A low frame strobe in the middle of a cycle abandons that cycle, and the low sample is considered as a possible fresh start.

For a selected memory read, the block lets the host's turnaround pass, then drives a ready sync nibble and the two nibbles of the read byte, and finally releases the bus again. The byte comes from an external array read port: the block presents the captured address, and the array returns data combinationally. Two active-low reset inputs are merged, so either one holds the block in reset with the bus released. When reset ends the device is in read mode and serves read cycles at once.

Top module: `lpc_target_fe`

## Requirements
- R1: A cycle starts only when, at a rising edge, `frame_n` is 0 and `bus_in` is 4'b0000. A low `frame_n` with any other nibble starts nothing, and the device stays silent.
- R2: A low `frame_n` while a cycle is in progress abandons it at once. If the nibble is 4'b0000 a new cycle starts at that edge; otherwise the block goes idle and never drives the bus for the abandoned cycle.
- R3: The nibble after the start is the cycle type. Only 4'b0100 (memory read) is served. Any other type is ignored until the next low `frame_n`, and the bus is not driven for it.
- R4: Eight address nibbles follow the type nibble, most significant first. `rd_addr` shows address bits [SEL_LSB-1:0] of the last selected read.
- R5: The device is selected only when address bits [SEL_LSB+1:SEL_LSB] equal the bitwise inverse of `strap` (strap 2'b00 answers 2'b11). A cycle that is not selected is ignored to its end, with `bus_oe` kept at 0.
- R6: After the last address nibble of a selected read, the bus stays undriven for TAR_CLKS clocks. Then one clock carries sync 4'b0000, one clock carries data bits [3:0] and one clock carries data bits [7:4]. The bus is then released for TAR_CLKS clocks.
- R7: `bus_oe` is 1 only in the sync and two data clocks of a selected read.
- R8: The internal reset is active while either `rst_a_n` or `rst_b_n` is 0. During reset `bus_oe` is 0, and any cycle in progress is lost.
- R9: When reset is released the device is in read mode, and the first selected read cycle is answered with array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, all sampling on the rising edge |
| rst_a_n | input | 1 | First active-low reset |
| rst_b_n | input | 1 | Second active-low reset |
| frame_n | input | 1 | Active-low cycle frame strobe |
| bus_in | input | 4 | Nibble sampled from the shared bus |
| bus_out | output | 4 | Nibble driven to the bus when enabled |
| bus_oe | output | 1 | Output enable for the bus drivers |
| strap | input | 2 | Device identity straps |
| rd_addr | output | SEL_LSB | Address presented to the array read port |
| rd_data | input | 8 | Byte returned by the array for rd_addr |

## Verification
The bench builds the block with the default parameters: eight address nibbles, select bits at 21:20, and two turnaround clocks. These are small enough to sweep every strap setting against every value of the two select bits, so all sixteen select outcomes are met, and each response is checked clock by clock against a byte computed from the address. The default depth also keeps the abort points within reach: inside the address, inside the turnaround, and at reset in the sync phase. A reset can then be followed by an immediate read.

// File: rtl/lpc_fe_pkg.sv
package lpc_fe_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_TYPE, ST_ADDR, ST_TAR, ST_SYNC, ST_DLO, ST_DHI, ST_REL, ST_SKIP
  } fe_state_t;

  localparam logic [3:0] START_NIB  = 4'b0000;
  localparam logic [3:0] READ_TYPE  = 4'b0100;
  localparam logic [3:0] SYNC_READY = 4'b0000;

  // straps are active-inverted: low strap demands a 1 in the address
  function automatic logic dev_match(input logic [1:0] sel_bits, input logic [1:0] straps);
    return sel_bits == ~straps;
  endfunction

  function automatic logic [3:0] pick_nibble(input logic [7:0] b, input logic upper);
    return upper ? b[7:4] : b[3:0];
  endfunction

endpackage

// File: rtl/lpc_rst_merge.sv
module lpc_rst_merge (
  input  logic a_n,
  input  logic b_n,
  output logic rst_n
);
  assign rst_n = a_n & b_n;
endmodule

// File: rtl/lpc_addr_shift.sv
module lpc_addr_shift #(
  parameter int CAP_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [3:0]       nib_in,
  output logic [CAP_W-1:0] cap,
  output logic [CAP_W-1:0] cap_next
);
  // upper address bits fall off the top: only select and array bits are kept
  assign cap_next = {cap[CAP_W-5:0], nib_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap <= '0;
    else if (shift_en) cap <= cap_next;
  end
endmodule

// File: rtl/lpc_cycle_fsm.sv
module lpc_cycle_fsm
  import lpc_fe_pkg::*;
#(
  parameter int ADDR_NIBS = 8,
  parameter int TAR_CLKS  = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_n,
  input  logic [3:0] bus_in,
  input  logic      sel_hit,
  output fe_state_t state,
  output logic      cyc_start,
  output logic      cyc_abort,
  output logic      addr_done,
  output logic      shift_en,
  output logic      load_data
);
  localparam int MAXC  = (ADDR_NIBS > TAR_CLKS) ? ADDR_NIBS : TAR_CLKS;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] TAR_LAST  = CNT_W'(TAR_CLKS - 1);

  fe_state_t        nxt;
  logic [CNT_W-1:0] cnt, cnt_n;

  assign cyc_start = !frame_n && (bus_in == START_NIB);
  assign cyc_abort = !frame_n && (state != ST_IDLE);
  assign shift_en  = frame_n && (state == ST_ADDR);
  assign addr_done = shift_en && (cnt == ADDR_LAST);
  assign load_data = frame_n && (state == ST_TAR) && (cnt == TAR_LAST);

  always_comb begin
    nxt   = state;
    cnt_n = cnt;
    if (!frame_n) begin
      nxt   = cyc_start ? ST_TYPE : ST_IDLE;
      cnt_n = '0;
    end else begin
      case (state)
        ST_TYPE: begin
          nxt   = (bus_in == READ_TYPE) ? ST_ADDR : ST_SKIP;
          cnt_n = '0;
        end
        ST_ADDR: begin
          if (addr_done) begin
            nxt   = sel_hit ? ST_TAR : ST_SKIP;
            cnt_n = '0;
          end else cnt_n = cnt + 1'b1;
        end
        ST_TAR: begin
          if (load_data) begin
            nxt   = ST_SYNC;
            cnt_n = '0;
          end else cnt_n = cnt + 1'b1;
        end
        ST_SYNC: nxt = ST_DLO;
        ST_DLO:  nxt = ST_DHI;
        ST_DHI: begin
          nxt   = ST_REL;
          cnt_n = '0;
        end
        ST_REL: begin
          if (cnt == TAR_LAST) nxt = ST_IDLE;
          else cnt_n = cnt + 1'b1;
        end
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= cnt_n;
    end
  end
endmodule

// File: rtl/lpc_bus_drive.sv
module lpc_bus_drive
  import lpc_fe_pkg::*;
(
  input  logic      rst_n,
  input  fe_state_t state,
  input  logic [7:0] data_q,
  output logic [3:0] bus_out,
  output logic      bus_oe
);
  always_comb begin
    bus_oe  = 1'b0;
    bus_out = 4'b0000;
    case (state)
      ST_SYNC: begin bus_oe = 1'b1; bus_out = SYNC_READY; end
      ST_DLO:  begin bus_oe = 1'b1; bus_out = pick_nibble(data_q, 1'b0); end
      ST_DHI:  begin bus_oe = 1'b1; bus_out = pick_nibble(data_q, 1'b1); end
      default: ;
    endcase
    if (!rst_n) bus_oe = 1'b0;
  end
endmodule

// File: rtl/lpc_target_fe.sv
module lpc_target_fe
  import lpc_fe_pkg::*;
#(
  parameter int ADDR_NIBS = 8,
  parameter int SEL_LSB   = 20,
  parameter int TAR_CLKS  = 2
) (
  input  logic               clk,
  input  logic               rst_a_n,
  input  logic               rst_b_n,
  input  logic               frame_n,
  input  logic [3:0]         bus_in,
  output logic [3:0]         bus_out,
  output logic               bus_oe,
  input  logic [1:0]         strap,
  output logic [SEL_LSB-1:0] rd_addr,
  input  logic [7:0]         rd_data
);
  localparam int CAP_W = SEL_LSB + 2;

  logic             rst_n;
  fe_state_t        state;
  logic             cyc_start, cyc_abort, addr_done, shift_en, load_data, sel_hit;
  logic [CAP_W-1:0] cap, cap_next;
  logic [7:0]       data_q;

  lpc_rst_merge u_rst (.a_n(rst_a_n), .b_n(rst_b_n), .rst_n(rst_n));

  lpc_addr_shift #(.CAP_W(CAP_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .nib_in(bus_in),
    .cap(cap), .cap_next(cap_next)
  );

  assign sel_hit = dev_match(cap_next[SEL_LSB +: 2], strap);

  lpc_cycle_fsm #(.ADDR_NIBS(ADDR_NIBS), .TAR_CLKS(TAR_CLKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in), .sel_hit(sel_hit),
    .state(state), .cyc_start(cyc_start), .cyc_abort(cyc_abort),
    .addr_done(addr_done), .shift_en(shift_en), .load_data(load_data)
  );

  // array address is held from the selected address until the next one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr <= '0;
      data_q  <= '0;
    end else begin
      if (addr_done && sel_hit) rd_addr <= cap_next[SEL_LSB-1:0];
      if (load_data)            data_q  <= rd_data;
    end
  end

  lpc_bus_drive u_drv (
    .rst_n(rst_n), .state(state), .data_q(data_q), .bus_out(bus_out), .bus_oe(bus_oe)
  );
endmodule

// File: rtl/lpc_fe_chk.sv
module lpc_fe_chk
  import lpc_fe_pkg::*;
(
  input logic      clk,
  input logic      rst_a_n,
  input logic      rst_b_n,
  input logic      rst_n,
  input logic      frame_n,
  input logic [3:0] bus_in,
  input logic      bus_oe,
  input logic [3:0] bus_out,
  input fe_state_t state,
  input logic      cyc_start,
  input logic      addr_done,
  input logic      sel_hit
);
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> state == ST_TYPE);

  p_abort_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && state != ST_IDLE && bus_in != START_NIB) |=> state == ST_IDLE);

  p_type_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && state == ST_TYPE && bus_in != READ_TYPE) |=> state == ST_SKIP);

  p_unselected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !sel_hit) |=> (state == ST_SKIP && !bus_oe));

  p_sync_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> bus_out == SYNC_READY);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DHI && frame_n) |=> !bus_oe);

  p_oe_after_tar_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(state) == ST_TAR);

  p_reset_quiet_r8: assert property (@(posedge clk)
    (!rst_a_n || !rst_b_n) |-> !bus_oe);
endmodule

bind lpc_target_fe lpc_fe_chk u_chk (
  .clk(clk), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n), .rst_n(rst_n),
  .frame_n(frame_n), .bus_in(bus_in), .bus_oe(bus_oe), .bus_out(bus_out),
  .state(state), .cyc_start(cyc_start), .addr_done(addr_done), .sel_hit(sel_hit)
);

// File: tb/tb_lpc_target_fe.sv
module tb_lpc_target_fe;
  logic        clk = 1'b0;
  logic        rst_a_n = 1'b0, rst_b_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  bus_in = 4'hF;
  logic [3:0]  bus_out;
  logic        bus_oe;
  logic [1:0]  strap = 2'b00;
  logic [19:0] rd_addr;
  logic [7:0]  rd_data;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h5A;
  endfunction
  assign rd_data = mem_byte(rd_addr);

  lpc_target_fe dut (
    .clk(clk), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n), .frame_n(frame_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .strap(strap),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] seen();
    return {bus_oe, bus_oe ? bus_out : 4'h0};
  endfunction

  task automatic drive(input logic fr, input logic [3:0] nib);
    @(negedge clk);
    frame_n = fr;
    bus_in  = nib;
  endtask

  task automatic send(input logic [3:0] st, input logic [3:0] ty, input logic [31:0] a);
    drive(1'b0, st);
    drive(1'b1, ty);
    for (int i = 7; i >= 0; i--) drive(1'b1, a[i*4 +: 4]);
  endtask

  // expect the 7 clocks after the last address nibble
  task automatic expect_resp(input logic [31:0] a, input logic hit, input string req);
    logic [7:0] b = mem_byte(a[19:0]);
    logic [4:0] exp [7];
    exp[0] = 5'h00; exp[1] = 5'h00; exp[2] = 5'h10;
    exp[3] = {1'b1, b[3:0]}; exp[4] = {1'b1, b[7:4]};
    exp[5] = 5'h00; exp[6] = 5'h00;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      chk(req, seen(), hit ? exp[k] : 5'h00);
      frame_n = 1'b1;
      bus_in  = 4'hF;
    end
  endtask

  task automatic quiet(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(req, seen(), 5'h00);
    end
  endtask

  initial begin
    logic [31:0] a;
    repeat (3) @(negedge clk);
    chk("R8 reset state", seen(), 5'h00);
    rst_a_n = 1'b1;
    @(negedge clk);
    chk("R8 one reset still low", seen(), 5'h00);
    rst_b_n = 1'b1;

    // R5/R6/R4 sweep: every strap against every select value
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 4; d++) begin
        strap = 2'(s);
        a = {10'h2A5, 2'(d), 20'(32'h1234 + s * 4099 + d * 911)};
        send(4'h0, 4'h4, a);
        expect_resp(a, (2'(d) == ~2'(s)), "R5 R6 R7 select sweep");
        if (2'(d) == ~2'(s)) chk("R4 rd_addr", {1'b0, rd_addr[3:0]}, {1'b0, a[3:0]});
      end
    end
    strap = 2'b00;

    // R1: low frame with non-start nibble starts nothing
    a = {12'hFF3, 20'hABCDE};
    send(4'h5, 4'h4, a);
    expect_resp(a, 1'b0, "R1 bad start nibble");
    send(4'h0, 4'h4, a);
    expect_resp(a, 1'b1, "R1 good start");

    // R3: non-read types ignored
    send(4'h0, 4'h6, a);
    expect_resp(a, 1'b0, "R3 write type ignored");
    send(4'h0, 4'h5, a);
    expect_resp(a, 1'b0, "R3 odd type ignored");

    // R2: abort inside address, restart with a start nibble
    drive(1'b0, 4'h0); drive(1'b1, 4'h4);
    drive(1'b1, 4'hF); drive(1'b1, 4'hF); drive(1'b1, 4'h3);
    a = {12'h0F3, 20'h13579};
    send(4'h0, 4'h4, a);
    expect_resp(a, 1'b1, "R2 restart after abort");

    // R2: abort in turnaround with non-start nibble
    send(4'h0, 4'h4, a);
    @(negedge clk);
    chk("R2 tar before abort", seen(), 5'h00);
    frame_n = 1'b0; bus_in = 4'hA;
    @(negedge clk);
    frame_n = 1'b1; bus_in = 4'hF;
    quiet(7, "R2 abort in turnaround");

    // R8 via first reset during turnaround, then R9
    send(4'h0, 4'h4, a);
    @(negedge clk);
    rst_a_n = 1'b0;
    quiet(6, "R8 reset a mid cycle");
    rst_a_n = 1'b1;
    a = {12'h003, 20'h8F0E1};
    send(4'h0, 4'h4, a);
    expect_resp(a, 1'b1, "R9 read after reset a");

    // R8 via second reset during sync, then R9
    send(4'h0, 4'h4, a);
    repeat (3) @(negedge clk);
    chk("R6 sync before reset", seen(), 5'h10);
    rst_b_n = 1'b0;
    #1;
    chk("R8 reset b drops oe", seen(), 5'h00);
    quiet(4, "R8 reset b held");
    rst_b_n = 1'b1;
    a = {12'hC03, 20'h00F5A};
    send(4'h0, 4'h4, a);
    expect_resp(a, 1'b1, "R9 read after reset b");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule